// File: doc/BRIEF.md
# Backward-Indexed Vector Loop Controller

This block sequences an array loop that walks a vector register through memory from the front of the array toward its end. It is loaded once with a pointer one past the final array element, a total element count, an element size and the largest vector length the hardware allows. It then presents, one iteration at a time, the byte address of the next memory operand, the number of elements that iteration may carry and a flag marking the final iteration. Each accepted step moves it on to the next iteration.

A single down-counting register holds the number of elements still to process. That register is used twice. It is the backward index: it is scaled to bytes and subtracted from the end pointer to form the address. It is also the requested vector length, which the block caps at the hardware maximum. Every iteration except the last therefore receives the full maximum, and the last receives exactly what is left, so a loop needs no cleanup pass for leftover elements. The granted length is meant to travel with the loaded vector, so that later consumers know how many elements are valid.

Top module: `vloop_ctrl`

## Requirements
- R1: While an iteration is offered (`iter_valid` high), `iter_len` equals the smaller of `remaining` and the effective maximum length, and it is never zero.
- R2: A start with a nonzero count loads `remaining` with `total_cnt`. Each step accepted while `iter_valid` is high lowers `remaining` by the `iter_len` of that iteration.
- R3: `iter_addr` equals `end_ptr` minus `remaining` multiplied by the element size. The element size is encoded in `elem_sz`: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.
- R4: `iter_last` is high exactly when `remaining` is no larger than the effective maximum. A step accepted while it is high ends the loop: on the next cycle `done` is high and `iter_valid` is low.
- R5: A 10-element loop is granted 4, 4, 2 when the maximum is 4; 8, 2 when the maximum is 8; and a single 10 when the maximum is 16.
- R6: A start with `total_cnt` of zero sets `done` on the next cycle. No iteration is ever offered for it.
- R7: A step while no iteration is offered has no effect: `remaining`, `done` and `iter_valid` keep their values.
- R8: `hw_max` is sampled only at start, and later changes to it do not affect the running loop. A sampled value of 0, or one above parameter `MAXVL`, is treated as `MAXVL`.
- R9: A start pulse while a loop is running is ignored. The count, address and grant continue unchanged.
- R10: After reset, `iter_valid` and `done` are low and `remaining` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop; accepted only when no loop is running |
| step | input | 1 | Consume the offered iteration |
| end_ptr | input | ADDR_W | Byte address just past the last array element |
| total_cnt | input | CNT_W | Number of elements in the array |
| elem_sz | input | 2 | Element size code (0:1, 1:2, 2:4, 3:8 bytes) |
| hw_max | input | VL_W | Hardware maximum vector length, in elements |
| iter_valid | output | 1 | An iteration is offered |
| iter_addr | output | ADDR_W | Memory operand address of the offered iteration |
| iter_len | output | VL_W | Granted vector length of the offered iteration |
| iter_last | output | 1 | The offered iteration is the final one |
| done | output | 1 | Loop finished; held until the next start |
| remaining | output | CNT_W | Elements still to process (the backward index) |

## Verification
The block has a single piece of state, the backward index, so nearly any fault in it shows at the ports on the very next cycle. An off-by-grant decrement moves `iter_addr` by the wrong number of bytes in the following iteration. A missed saturation shows as an `iter_len` above the maximum, and a wrong last-iteration test shows either as a `done` that never arrives or as an iteration offered after `done`. The directed scenarios compare `iter_addr`, `iter_len`, `iter_last` and `remaining` in every iteration against values worked out by hand, so a divergence is reported in the iteration where it first appears.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_MAXVL  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } loop_st_e;

    typedef enum logic [1:0] {
        ESZ_B1 = 2'd0,
        ESZ_B2 = 2'd1,
        ESZ_B4 = 2'd2,
        ESZ_B8 = 2'd3
    } esz_e;

    // log2 of the element size in bytes
    function automatic logic [1:0] esz_shift(input esz_e e);
        return logic'(e[1]) ? {1'b1, e[0]} : {1'b0, e[0]};
    endfunction

endpackage

// File: rtl/vloop_grant.sv
module vloop_grant #(
    parameter int CNT_W = 16,
    parameter int VL_W  = 5
) (
    input  logic [CNT_W-1:0] idx,
    input  logic [VL_W-1:0]  maxv,
    output logic [VL_W-1:0]  len,
    output logic             last
);
    // requested length is the backward index itself; cap at maxv
    always_comb begin
        last = (idx <= CNT_W'(maxv));
        len  = last ? idx[VL_W-1:0] : maxv;
    end
endmodule

// File: rtl/vloop_addr.sv
module vloop_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] end_q,
    input  logic [CNT_W-1:0]  idx,
    input  vloop_pkg::esz_e   esz,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] byte_off;

    always_comb begin
        byte_off = ADDR_W'(idx) << vloop_pkg::esz_shift(esz);
        addr     = end_q - byte_off;
    end
endmodule

// File: rtl/vloop_state.sv
module vloop_state #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int MAXVL  = 16,
    parameter int VL_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 step,
    input  logic [ADDR_W-1:0]    end_ptr,
    input  logic [CNT_W-1:0]     total_cnt,
    input  logic [1:0]           elem_sz,
    input  logic [VL_W-1:0]      hw_max,
    input  logic [VL_W-1:0]      grant_len,
    input  logic                 grant_last,
    output vloop_pkg::loop_st_e  st_q,
    output logic [CNT_W-1:0]     idx_q,
    output logic [ADDR_W-1:0]    end_q,
    output vloop_pkg::esz_e      esz_q,
    output logic [VL_W-1:0]      maxv_q
);
    import vloop_pkg::*;

    localparam logic [VL_W-1:0] MAXVL_V = VL_W'(MAXVL);

    logic            running;
    logic            take_start;
    logic            take_step;
    logic [VL_W-1:0] eff_max;

    always_comb begin
        running    = (st_q == ST_RUN);
        take_start = start && !running;
        take_step  = step && running;
        eff_max    = (hw_max == '0 || hw_max > MAXVL_V) ? MAXVL_V : hw_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            end_q  <= '0;
            esz_q  <= ESZ_B1;
            maxv_q <= MAXVL_V;
        end else if (take_start) begin
            idx_q  <= total_cnt;
            end_q  <= end_ptr;
            esz_q  <= esz_e'(elem_sz);
            maxv_q <= eff_max;
            st_q   <= (total_cnt == '0) ? ST_DONE : ST_RUN;
        end else if (take_step) begin
            idx_q <= idx_q - CNT_W'(grant_len);
            if (grant_last) st_q <= ST_DONE;
        end
    end

    AST_MAX_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> $stable(maxv_q)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (running && start && !step) |=> $stable(idx_q) && $stable(end_q)); // R9

endmodule

// File: rtl/vloop_ctrl.sv
module vloop_ctrl #(
    parameter int ADDR_W = vloop_pkg::DEF_ADDR_W,
    parameter int CNT_W  = vloop_pkg::DEF_CNT_W,
    parameter int MAXVL  = vloop_pkg::DEF_MAXVL,
    localparam int VL_W  = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [CNT_W-1:0]  total_cnt,
    input  logic [1:0]        elem_sz,
    input  logic [VL_W-1:0]   hw_max,
    output logic              iter_valid,
    output logic [ADDR_W-1:0] iter_addr,
    output logic [VL_W-1:0]   iter_len,
    output logic              iter_last,
    output logic              done,
    output logic [CNT_W-1:0]  remaining
);
    import vloop_pkg::*;

    loop_st_e          st_q;
    logic [CNT_W-1:0]  idx_q;
    logic [ADDR_W-1:0] end_q;
    esz_e              esz_q;
    logic [VL_W-1:0]   maxv_q;
    logic [VL_W-1:0]   g_len;
    logic              g_last;

    vloop_state #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAXVL(MAXVL), .VL_W(VL_W)
    ) u_state (
        .clk(clk), .rst(rst), .start(start), .step(step),
        .end_ptr(end_ptr), .total_cnt(total_cnt), .elem_sz(elem_sz),
        .hw_max(hw_max), .grant_len(g_len), .grant_last(g_last),
        .st_q(st_q), .idx_q(idx_q), .end_q(end_q), .esz_q(esz_q),
        .maxv_q(maxv_q)
    );

    vloop_grant #(.CNT_W(CNT_W), .VL_W(VL_W)) u_grant (
        .idx(idx_q), .maxv(maxv_q), .len(g_len), .last(g_last)
    );

    vloop_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .end_q(end_q), .idx(idx_q), .esz(esz_q), .addr(iter_addr)
    );

    always_comb begin
        iter_valid = (st_q == ST_RUN);
        iter_len   = g_len;
        iter_last  = g_last;
        done       = (st_q == ST_DONE);
        remaining  = idx_q;
    end

    AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (rst)
        iter_valid |-> (iter_len != '0 && CNT_W'(iter_len) <= remaining)); // R1

    AST_REM_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (iter_valid && step) |=> remaining == $past(remaining) - CNT_W'($past(iter_len))); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (iter_valid && step && iter_last) |=> (done && !iter_valid)); // R4

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!iter_valid && !start) |=> ($stable(remaining) && $stable(done) && !iter_valid)); // R7

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(done && iter_valid)); // R6

endmodule

// File: tb/sim_vloop_ctrl.sv
module sim_vloop_ctrl;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int MAXVL  = 16;
    localparam int VL_W   = $clog2(MAXVL + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              step = 1'b0;
    logic [ADDR_W-1:0] end_ptr = '0;
    logic [CNT_W-1:0]  total_cnt = '0;
    logic [1:0]        elem_sz = '0;
    logic [VL_W-1:0]   hw_max = '0;
    logic              iter_valid;
    logic [ADDR_W-1:0] iter_addr;
    logic [VL_W-1:0]   iter_len;
    logic              iter_last;
    logic              done;
    logic [CNT_W-1:0]  remaining;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    vloop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAXVL(MAXVL)) u0 (
        .clk(clk), .rst(rst), .start(start), .step(step),
        .end_ptr(end_ptr), .total_cnt(total_cnt), .elem_sz(elem_sz),
        .hw_max(hw_max), .iter_valid(iter_valid), .iter_addr(iter_addr),
        .iter_len(iter_len), .iter_last(iter_last), .done(done),
        .remaining(remaining)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // all inputs change at negedge; outputs are sampled there too
    task automatic begin_loop(input logic [ADDR_W-1:0] e, input int cnt,
                              input int esz, input int mx);
        @(negedge clk);
        end_ptr = e; total_cnt = CNT_W'(cnt);
        elem_sz = 2'(esz); hw_max = VL_W'(mx); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_iter(input string req, input int rem, input int len,
                               input logic [ADDR_W-1:0] addr, input bit last);
        chk(req, "iter_valid", iter_valid, 1);
        chk(req, "remaining", remaining, rem);
        chk(req, "iter_len", iter_len, len);
        chk(req, "iter_addr", iter_addr, addr);
        chk(req, "iter_last", iter_last, last);
    endtask

    task automatic do_step;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic expect_done(input string req);
        chk(req, "done", done, 1);
        chk(req, "iter_valid", iter_valid, 0);
        chk(req, "remaining", remaining, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "iter_valid", iter_valid, 0);
        chk("R10", "done", done, 0);
        chk("R10", "remaining", remaining, 0);
        do_step(); // R7: step with nothing offered
        chk("R7", "iter_valid after idle step", iter_valid, 0);
        chk("R7", "done after idle step", done, 0);
        chk("R7", "remaining after idle step", remaining, 0);
    endtask

    task automatic t_ten_by_four; // R5, R3 with 4-byte elements
        begin_loop(32'h1000, 10, 2, 4);
        expect_iter("R5", 10, 4, 32'h0FD8, 1'b0);
        do_step();
        expect_iter("R2", 6, 4, 32'h0FE8, 1'b0);
        do_step();
        expect_iter("R4", 2, 2, 32'h0FF8, 1'b1);
        do_step();
        expect_done("R4");
    endtask

    task automatic t_ten_by_eight; // R5, R3 with 8-byte elements
        begin_loop(32'h2000, 10, 3, 8);
        expect_iter("R5", 10, 8, 32'h1FB0, 1'b0);
        do_step();
        expect_iter("R3", 2, 2, 32'h1FF0, 1'b1);
        do_step();
        expect_done("R5");
    endtask

    task automatic t_ten_by_sixteen; // R5, R3 with 1-byte elements
        begin_loop(32'h0300, 10, 0, 16);
        expect_iter("R5", 10, 10, 32'h02F6, 1'b1);
        do_step();
        expect_done("R5");
        do_step(); // R7: step after done
        expect_done("R7");
    endtask

    task automatic t_zero_count; // R6
        begin_loop(32'h4000, 0, 2, 4);
        chk("R6", "done", done, 1);
        chk("R6", "iter_valid", iter_valid, 0);
        do_step();
        chk("R6", "iter_valid after step", iter_valid, 0);
        chk("R6", "done held", done, 1);
    endtask

    task automatic t_frozen_max; // R8, R9, 2-byte elements
        begin_loop(32'h0100, 20, 1, 0); // 0 means MAXVL
        expect_iter("R8", 20, 16, 32'h00D8, 1'b0);
        hw_max = VL_W'(2);
        total_cnt = CNT_W'(3);
        end_ptr = 32'h9000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expect_iter("R9", 20, 16, 32'h00D8, 1'b0);
        do_step();
        expect_iter("R8", 4, 4, 32'h00F8, 1'b1);
        do_step();
        expect_done("R8");
    endtask

    task automatic t_over_max; // R8, R1: hw_max above MAXVL clamps
        begin_loop(32'h0800, 17, 2, 31);
        expect_iter("R1", 17, 16, 32'h07BC, 1'b0);
        do_step();
        expect_iter("R1", 1, 1, 32'h07FC, 1'b1);
        do_step();
        expect_done("R1");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ten_by_four();
        t_ten_by_eight();
        t_ten_by_sixteen();
        t_zero_count();
        t_frozen_max();
        t_over_max();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule